// File: doc/BRIEF.md
# Configuration Frame Word Packer

This block builds one vertical configuration frame from fixed-size bit segments and streams it out as 32-bit words. It has two modes. In the narrow mode, used for logic and I/O columns, every input segment carries 18 bits. In the wide mode, used for memory-content columns, every input segment carries one 72-bit memory row. The block adds an 18-bit zero field above and below the rows by itself. The frame runs from the top of the array to the bottom. Its bits are packed most-significant-first into consecutive words, and the tail of the last word is filled with zeros.

A start-of-frame pulse selects the mode and clears any partial frame. After that pulse, the producer streams segments over a valid/ready handshake, and the consumer drains words over its own valid/ready handshake. A word-last flag marks the final padded word. The parameter `ROWS` sets the number of logic rows. A memory column holds `ROWS/4` rows, so both modes give frames of the same length.

Top module: `frame_word_packer`

## Requirements
- R1: After reset, word_valid and word_last are low, and seg_ready stays low until a start-of-frame pulse arrives.
- R2: With mode_ram=0 at start-of-frame, exactly ROWS+2 segments are accepted. Each segment is taken from seg_data[17:0], and seg_data[71:18] is ignored. The frame body is 18*(ROWS+2) bits.
- R3: The first frame bit goes to word_data[31] of the first word. Each segment enters with its most significant bit first, and the bit stream continues across word boundaries without gaps.
- R4: Zeros are appended after the frame body up to a whole number of words. This is ceil(18*(ROWS+2)/32) words, which is 11 words with 28 zero bits for ROWS=16.
- R5: With mode_ram=1 at start-of-frame, the frame is built in this order: 18 zero bits, then ROWS/4 segments taken from seg_data[71:0], then 18 zero bits, then the R4 padding.
- R6: The mode is sampled only at start-of-frame. Changing mode_ram during a frame has no effect.
- R7: word_last is high on the final padded word of a frame and on no other word.
- R8: seg_ready is low in any cycle where word_valid is high and word_ready is low.
- R9: While word_valid is high and word_ready is low, word_data and word_last hold their values.
- R10: A start-of-frame pulse discards any partial frame. In the next cycle word_valid is low, and the new frame contains no bits from the old one.
- R11: Once the last segment of a frame has been accepted, seg_ready stays low until the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; latches mode and clears the accumulator |
| mode_ram | input | 1 | 0: 18-bit segments; 1: 72-bit memory rows with zero fields |
| seg_data | input | 72 | Segment bits, MSB first; narrow mode uses [17:0] |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high together with seg_valid |
| word_data | output | 32 | Packed output word |
| word_valid | output | 1 | Output word present |
| word_ready | input | 1 | Consumer takes the word |
| word_last | output | 1 | Final padded word of the frame |

## Verification
The hardest case to reach from the ports is a start-of-frame that lands while an unfinished frame still holds bits in the accumulator and a word sits stalled in the output register. The bench creates this case directly. It holds word_ready low, feeds only two narrow segments so that the first word is formed and stalls, and then pulses start-of-frame in the wide mode. A complete frame follows, and it must show no trace of the abandoned bits. Random backpressure on word_ready, together with junk in the unused upper segment bits, exercises the stall path and the bits that must be ignored.

// File: rtl/frame_pack_pkg.sv
`timescale 1ns/1ps
package frame_pack_pkg;

    localparam int WORD_W   = 32;
    localparam int NARROW_W = 18;
    localparam int WIDE_W   = 72;
    localparam int ACC_W    = WORD_W + WIDE_W;
    localparam int CNT_W    = $clog2(ACC_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL,
        ST_FLUSH
    } pk_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PUSH,
        OP_PAD,
        OP_POP
    } pk_op_e;

    typedef struct packed {
        pk_op_e op;
        logic   wide;
        logic   last;
    } pk_cmd_t;

    function automatic int frame_words(input int rows);
        return (NARROW_W * (rows + 2) + WORD_W - 1) / WORD_W;
    endfunction

endpackage

// File: rtl/frame_pack_seq.sv
`timescale 1ns/1ps
module frame_pack_seq
    import frame_pack_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             mode_ram,
    input  logic             seg_valid,
    input  logic [CNT_W-1:0] acc_cnt,
    input  logic             out_valid,
    input  logic             word_ready,
    output logic             seg_ready,
    output pk_cmd_t          cmd
);
    localparam int RAM_ROWS    = ROWS / 4;
    localparam int NARROW_SEGS = ROWS + 2;
    localparam int SC_W        = $clog2(NARROW_SEGS + 1);

    pk_state_e         state_q;
    logic [SC_W-1:0]   seg_cnt_q;
    logic              wide_q;
    logic              out_free;
    logic              room;
    logic              final_seg;

    assign out_free  = !out_valid || word_ready;
    assign room      = acc_cnt <= CNT_W'(WORD_W);
    assign final_seg = wide_q ? (seg_cnt_q == SC_W'(RAM_ROWS - 1))
                              : (seg_cnt_q == SC_W'(NARROW_SEGS - 1));
    assign seg_ready = (state_q == ST_BODY) && room && !out_valid && !sof;

    always_comb begin
        cmd.op   = OP_NONE;
        cmd.wide = wide_q;
        cmd.last = 1'b0;
        if (!sof) begin
            if (state_q == ST_FLUSH) begin
                if (out_free) begin
                    cmd.op   = OP_POP;
                    cmd.last = room;
                end
            end else if (state_q != ST_IDLE && !room) begin
                if (out_free) begin
                    cmd.op = OP_POP;
                end
            end else begin
                case (state_q)
                    ST_HEAD, ST_TAIL: cmd.op = OP_PAD;
                    ST_BODY:          if (seg_valid && seg_ready) cmd.op = OP_PUSH;
                    default:          cmd.op = OP_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            seg_cnt_q <= '0;
            wide_q    <= 1'b0;
        end else if (sof) begin
            state_q   <= mode_ram ? ST_HEAD : ST_BODY;
            seg_cnt_q <= '0;
            wide_q    <= mode_ram;
        end else begin
            case (state_q)
                ST_HEAD: if (cmd.op == OP_PAD) state_q <= ST_BODY;
                ST_BODY: begin
                    if (cmd.op == OP_PUSH) begin
                        seg_cnt_q <= seg_cnt_q + 1'b1;
                        if (final_seg) state_q <= wide_q ? ST_TAIL : ST_FLUSH;
                    end
                end
                ST_TAIL: if (cmd.op == OP_PAD) state_q <= ST_FLUSH;
                ST_FLUSH: if (cmd.op == OP_POP && cmd.last) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/frame_pack_acc.sv
`timescale 1ns/1ps
module frame_pack_acc
    import frame_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  pk_cmd_t           cmd,
    input  logic [WIDE_W-1:0] seg_data,
    input  logic              word_ready,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_last
);
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] aligned;
    logic [ACC_W-1:0] placed;
    logic [CNT_W-1:0] add_bits;

    assign acc_cnt = cnt_q;

    always_comb begin
        if (cmd.wide) begin
            aligned  = {seg_data, {WORD_W{1'b0}}};
            add_bits = CNT_W'(WIDE_W);
        end else begin
            aligned  = {seg_data[NARROW_W-1:0], {(ACC_W - NARROW_W){1'b0}}};
            add_bits = CNT_W'(NARROW_W);
        end
        placed = aligned >> cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || sof) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
            out_last  <= 1'b0;
        end else begin
            case (cmd.op)
                OP_PUSH: begin
                    acc_q <= acc_q | placed;
                    cnt_q <= cnt_q + add_bits;
                end
                OP_PAD: begin
                    cnt_q <= cnt_q + CNT_W'(NARROW_W);
                end
                OP_POP: begin
                    out_word  <= acc_q[ACC_W-1 -: WORD_W];
                    acc_q     <= acc_q << WORD_W;
                    cnt_q     <= (cnt_q > CNT_W'(WORD_W)) ? cnt_q - CNT_W'(WORD_W) : '0;
                    out_valid <= 1'b1;
                    out_last  <= cmd.last;
                end
                default: ;
            endcase
            if (cmd.op != OP_POP && word_ready) begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/frame_word_packer.sv
`timescale 1ns/1ps
module frame_word_packer
    import frame_pack_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sof,
    input  logic        mode_ram,
    input  logic [71:0] seg_data,
    input  logic        seg_valid,
    output logic        seg_ready,
    output logic [31:0] word_data,
    output logic        word_valid,
    input  logic        word_ready,
    output logic        word_last
);
    pk_cmd_t          cmd;
    logic [CNT_W-1:0] acc_cnt;

    frame_pack_seq #(.ROWS(ROWS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .mode_ram   (mode_ram),
        .seg_valid  (seg_valid),
        .acc_cnt    (acc_cnt),
        .out_valid  (word_valid),
        .word_ready (word_ready),
        .seg_ready  (seg_ready),
        .cmd        (cmd)
    );

    frame_pack_acc u_acc (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .cmd        (cmd),
        .seg_data   (seg_data),
        .word_ready (word_ready),
        .acc_cnt    (acc_cnt),
        .out_valid  (word_valid),
        .out_word   (word_data),
        .out_last   (word_last)
    );

endmodule

// File: rtl/frame_word_packer_chk.sv
`timescale 1ns/1ps
module frame_word_packer_chk
    import frame_pack_pkg::*;
#(
    parameter int ROWS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        sof,
    input logic        seg_ready,
    input logic [31:0] word_data,
    input logic        word_valid,
    input logic        word_ready,
    input logic        word_last
);
    localparam int WORDS = frame_words(ROWS);

    logic [7:0] taken_q;

    always_ff @(posedge clk) begin
        if (rst || sof) taken_q <= '0;
        else if (word_valid && word_ready) taken_q <= taken_q + 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!word_valid && !word_last && !seg_ready));

    // R8
    no_accept_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |-> !seg_ready);

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready && !sof) |=>
            (word_valid && $stable(word_data) && $stable(word_last)));

    // R10
    sof_flush_chk: assert property (@(posedge clk) disable iff (rst)
        sof |=> !word_valid);

    // R7
    last_position_chk: assert property (@(posedge clk) disable iff (rst || sof)
        (word_valid && word_ready && word_last) |-> (taken_q == 8'(WORDS - 1)));

    // R4
    frame_length_chk: assert property (@(posedge clk) disable iff (rst || sof)
        (word_valid && word_ready && !word_last) |-> (taken_q < 8'(WORDS - 1)));

endmodule

bind frame_word_packer frame_word_packer_chk #(.ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .seg_ready  (seg_ready),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_last  (word_last)
);

// File: tb/frame_word_packer_test.sv
`timescale 1ns/1ps
module frame_word_packer_test;

    localparam int ROWS  = 16;
    localparam int WORDS = (18 * (ROWS + 2) + 31) / 32;
    localparam int FB    = WORDS * 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        mode_ram = 1'b0;
    logic [71:0] seg_data = '0;
    logic        seg_valid = 1'b0;
    logic        seg_ready;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_ready = 1'b0;
    logic        word_last;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    frame_word_packer #(.ROWS(ROWS)) uut (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .mode_ram   (mode_ram),
        .seg_data   (seg_data),
        .seg_valid  (seg_valid),
        .seg_ready  (seg_ready),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_last  (word_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_sof(input bit ram);
        @(negedge clk);
        mode_ram = ram;
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        mode_ram = ~ram;
    endtask

    task automatic drive_seg(input logic [71:0] d);
        seg_data  = d;
        seg_valid = 1'b1;
        #1;
        while (!seg_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic run_frame(input bit ram, input bit stall, input string req);
        logic [71:0]  segs [0:ROWS+1];
        logic [FB-1:0] exp;
        logic [31:0]  gw [0:63];
        bit           gl [0:63];
        int           ng = 0;
        int           nseg = ram ? ROWS / 4 : ROWS + 2;
        int           p = FB;
        int           nlast = 0;
        exp = '0;
        if (ram) p -= 18;
        for (int i = 0; i < nseg; i++) begin
            segs[i] = {8'($urandom), $urandom, $urandom};
            if (ram) begin
                exp[p-1 -: 72] = segs[i];
                p -= 72;
            end else begin
                exp[p-1 -: 18] = segs[i][17:0];
                p -= 18;
            end
        end
        pulse_sof(ram);
        fork
            begin
                for (int i = 0; i < nseg; i++) drive_seg(segs[i]);
            end
            begin
                bit done = 0;
                while (!done && ng < 64) begin
                    word_ready = stall ? ($urandom % 3 != 0) : 1'b1;
                    #1;
                    if (word_valid && !word_ready)
                        check(!seg_ready, "R8", "seg_ready while output full", 32'(seg_ready), 0);
                    if (word_valid && word_ready) begin
                        gw[ng] = word_data;
                        gl[ng] = word_last;
                        if (word_last) done = 1;
                        ng++;
                    end
                    @(negedge clk);
                end
                word_ready = 1'b1;
            end
        join
        check(ng == WORDS, "R4", {req, " word count"}, 32'(ng), 32'(WORDS));
        for (int w = 0; w < ng && w < WORDS; w++) begin
            check(gw[w] === exp[FB-1-32*w -: 32], ram ? "R5" : "R3",
                  {req, " word data"}, gw[w], exp[FB-1-32*w -: 32]);
            if (gl[w]) nlast++;
        end
        check(nlast == 1 && gl[ng-1], "R7", {req, " last placement"}, 32'(nlast), 1);
        // R11: extra segments after the frame are not taken
        seg_data = '1;
        seg_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(!seg_ready && !word_valid, "R11", {req, " idle after frame"},
                  {30'b0, seg_ready, word_valid}, 0);
            @(negedge clk);
        end
        seg_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!word_valid && !word_last, "R1", "outputs after reset", {30'b0, word_valid, word_last}, 0);
        check(!seg_ready, "R1", "seg_ready before sof", 32'(seg_ready), 0);
    endtask

    task automatic t_abort;
        logic [31:0] first;
        pulse_sof(1'b0);
        mode_ram = 1'b1;
        word_ready = 1'b0;
        first = {14'h0, 18'h2AAAA};
        drive_seg({54'h3F_FFFF_FFFF_FFFF, 18'h3FFFF});
        drive_seg({54'h0, 18'h0});
        repeat (3) @(negedge clk);
        #1;
        check(word_valid && word_data == {18'h3FFFF, 14'h0}, "R9", "stalled word held",
              word_data, {18'h3FFFF, 14'h0});
        check(!seg_ready, "R8", "seg_ready during stall", 32'(seg_ready), 0);
        pulse_sof(1'b1);
        #1;
        check(!word_valid, "R10", "output cleared by sof", 32'(word_valid), 0);
        word_ready = 1'b1;
        if (first == 0) ;
        run_frame(1'b1, 1'b1, "R10 after abort");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_frame(1'b0, 1'b0, "R2 narrow");
        run_frame(1'b0, 1'b1, "R2 narrow stalled");
        run_frame(1'b1, 1'b0, "R5 wide");
        run_frame(1'b1, 1'b1, "R6 wide stalled");
        t_abort();
        run_frame(1'b0, 1'b1, "R6 narrow after wide");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule